// File: doc/BRIEF.md
# Multi-Channel DMA Register Front End

This block is the register-facing side of a DMA controller with several channels. A 32-bit request bus reaches it with a byte-enable mask. The block splits each address into a channel index and a register offset inside that channel's window. For every channel it holds a two-bit configuration, the last stream command and a small run-state machine. The state machine follows the configuration bits and start events and packs into a readable status word. Accepted writes are turned into single-cycle command pulses for the channel engine: continue, load descriptor, load context and start.

The engine reports back through two inputs per channel. One says a client is attached to the channel. The other is a one-cycle strobe that sets the channel's end-of-list flag. Every request gets exactly one response, one cycle later, with read data and an error bit. Any command pulses raised by a write appear in that same response cycle.

Top module: `dma_chan_regfile`

## Requirements
- R1: The channel index is bus_addr shifted right by 13, since each channel has a 0x2000-byte window. The low 13 bits select a register: 0x0 configuration, 0x4 command (write only, reads 0), 0x8 stream command, 0xC status (read only, writes ignored). Each request is answered with resp_valid exactly one cycle later, and a write's pulses appear in that cycle.
- R2: The status word carries the run state in bits 2:0 (reset = 3'b001, stopped = 3'b010, running = 3'b100) and the end-of-list flag in bit 5. Bits 9:8 hold the command source field, which is fixed at 1. After reset every channel reads 0x101, and the run state always has exactly one bit set.
- R3: Configuration bit 0 is enable and bit 1 is stop, and both read back from offset 0x0. A configuration write with bit 1 set makes the state stopped. A write with bit 0 clear makes it reset, and reset wins when both apply. Any other configuration write leaves the state unchanged.
- R4: Only bits 9:0 of a stream command write are decoded and stored; reading offset 0x8 returns them. If bit 8 or bit 6 is set, a load-descriptor pulse is raised.
- R5: If a stream command requests a descriptor load and also has bit 5 set, the channel is started. Bit 5 on its own does nothing.
- R6: If a stream command has bit 9 set, a load-context pulse is raised and the channel is started.
- R7: Starting a channel whose client_present bit is high does three things: it clears the end-of-list flag, sets the state to running and raises start_pulse. Starting a channel without a client changes nothing and raises no start pulse; the load pulses are still issued.
- R8: A write to the command register raises cont_pulse only if four conditions all hold: enable is set, stop is clear, a client is present and the state is running.
- R9: A high eol_set bit sets that channel's end-of-list flag at the next edge. If a start happens in the same cycle, the flag still ends up set.
- R10: A request is rejected with resp_err high, read data 0, no pulse and no register change in three cases: its byte-enable mask is not all ones, it addresses a channel index of N_CH or above, or its offset is not one of the four registers.
- R11: Accesses to one channel leave every other channel's registers and state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_be | input | DATA_W/8 (4) | Byte enables; must be all ones |
| bus_wdata | input | DATA_W (32) | Write data |
| client_present | input | N_CH (4) | Client attached, per channel |
| eol_set | input | N_CH (4) | Engine strobe that sets end-of-list, per channel |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_err | output | 1 | Request was rejected |
| resp_rdata | output | DATA_W (32) | Read data (0 for writes and errors) |
| cont_pulse | output | N_CH (4) | Continue request, per channel |
| load_desc_pulse | output | N_CH (4) | Load-descriptor request, per channel |
| load_ctx_pulse | output | N_CH (4) | Load-context request, per channel |
| start_pulse | output | N_CH (4) | Channel started, per channel |

## Verification
Every result of a request is due one clock edge after the request is sampled: the response, its read data and every command pulse. A state change caused by a write can be seen through a status read issued in any later cycle. The driver queues the complete expected response at the moment it presents a request. The monitor compares that entry on the falling edge after the next rising edge. On every other falling edge the monitor checks that no pulse is raised. End-of-list strobes are held for one cycle and checked through a later status read.

// File: rtl/dma_chan_regfile_pkg.sv
package dma_chan_regfile_pkg;
   localparam int ST_W = 3;
   localparam logic [ST_W-1:0] ST_RESET   = 3'b001;
   localparam logic [ST_W-1:0] ST_STOPPED = 3'b010;
   localparam logic [ST_W-1:0] ST_RUNNING = 3'b100;

   localparam int OFF_CFG    = 'h0;
   localparam int OFF_CMD    = 'h4;
   localparam int OFF_STREAM = 'h8;
   localparam int OFF_STATUS = 'hC;

   localparam int CMD_BITS   = 10;
   localparam logic [CMD_BITS-1:0] LDD_MASK = 10'h140;
   localparam int BURST_BIT  = 5;
   localparam int LDC_BIT    = 9;

   localparam int EOL_POS    = 5;
   localparam int SRC_POS    = 8;
   localparam logic [1:0] SRC_ID = 2'd1;

   typedef enum logic [1:0] {
      SEL_CFG    = 2'd0,
      SEL_CMD    = 2'd1,
      SEL_STREAM = 2'd2,
      SEL_STATUS = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dma_chan_addr_dec.sv
module dma_chan_addr_dec
   import dma_chan_regfile_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_SHIFT = 13,
   parameter int N_CH      = 4,
   parameter int BE_W      = 4,
   localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int UP_W     = ADDR_W - WIN_SHIFT
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   output logic [CH_W-1:0]   ch,
   output reg_sel_e          sel,
   output logic              err
);
   logic [UP_W-1:0]      upper;
   logic [WIN_SHIFT-1:0] off;
   logic                 in_range;
   logic                 mapped;
   logic                 full_word;

   assign upper     = addr[ADDR_W-1:WIN_SHIFT];
   assign off       = addr[WIN_SHIFT-1:0];
   assign in_range  = (32'(upper) < N_CH);
   assign full_word = &be;
   assign ch        = upper[CH_W-1:0];

   always_comb begin
      mapped = 1'b1;
      sel    = SEL_CFG;
      if (off == WIN_SHIFT'(OFF_CFG))         sel = SEL_CFG;
      else if (off == WIN_SHIFT'(OFF_CMD))    sel = SEL_CMD;
      else if (off == WIN_SHIFT'(OFF_STREAM)) sel = SEL_STREAM;
      else if (off == WIN_SHIFT'(OFF_STATUS)) sel = SEL_STATUS;
      else                                    mapped = 1'b0;
   end

   assign err = !(in_range && mapped && full_word);
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
   import dma_chan_regfile_pkg::*;
#(
   parameter int CMD_W = CMD_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cfg,
   input  logic             wr_cmd,
   input  logic             wr_stream,
   input  logic [CMD_W-1:0] wdata,
   input  logic             client,
   input  logic             eol_in,
   output logic [1:0]       cfg_q,
   output logic [CMD_W-1:0] stream_q,
   output logic [ST_W-1:0]  state_q,
   output logic             eol_q,
   output logic             cont_p,
   output logic             ldd_p,
   output logic             ldc_p,
   output logic             start_p
);
   logic            want_ldd, want_ldc, want_start, start_ok, cont_ok;
   logic [ST_W-1:0] state_d;
   logic            eol_d;

   assign want_ldd   = wr_stream && |(wdata[CMD_BITS-1:0] & LDD_MASK);
   assign want_ldc   = wr_stream && wdata[LDC_BIT];
   assign want_start = (want_ldd && wdata[BURST_BIT]) || want_ldc;
   assign start_ok   = want_start && client;
   assign cont_ok    = wr_cmd && cfg_q[0] && !cfg_q[1] && client
                       && (state_q == ST_RUNNING);

   always_comb begin
      state_d = state_q;
      if (wr_cfg) begin
         if (wdata[1])  state_d = ST_STOPPED;
         if (!wdata[0]) state_d = ST_RESET;
      end
      if (start_ok) state_d = ST_RUNNING;
      eol_d = eol_q;
      if (start_ok) eol_d = 1'b0;
      if (eol_in)   eol_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         stream_q <= '0;
         state_q  <= ST_RESET;
         eol_q    <= 1'b0;
         cont_p   <= 1'b0;
         ldd_p    <= 1'b0;
         ldc_p    <= 1'b0;
         start_p  <= 1'b0;
      end else begin
         if (wr_cfg)    cfg_q    <= wdata[1:0];
         if (wr_stream) stream_q <= wdata;
         state_q <= state_d;
         eol_q   <= eol_d;
         cont_p  <= cont_ok;
         ldd_p   <= want_ldd;
         ldc_p   <= want_ldc;
         start_p <= start_ok;
      end
   end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
   import dma_chan_regfile_pkg::*;
#(
   parameter int N_CH      = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int WIN_SHIFT = 13,
   localparam int BE_W     = DATA_W / 8,
   localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [N_CH-1:0]   client_present,
   input  logic [N_CH-1:0]   eol_set,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [DATA_W-1:0] resp_rdata,
   output logic [N_CH-1:0]   cont_pulse,
   output logic [N_CH-1:0]   load_desc_pulse,
   output logic [N_CH-1:0]   load_ctx_pulse,
   output logic [N_CH-1:0]   start_pulse
);
   if (N_CH < 1) begin : g_bad_nch
      $error("N_CH must be at least 1");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_dw
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (WIN_SHIFT < 4 || WIN_SHIFT + CH_W > ADDR_W) begin : g_bad_aw
      $error("address too narrow for the channel windows");
   end

   logic [CH_W-1:0] dec_ch;
   reg_sel_e        dec_sel;
   logic            dec_err;

   dma_chan_addr_dec #(
      .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .N_CH(N_CH), .BE_W(BE_W)
   ) dec_i (
      .addr(bus_addr), .be(bus_be), .ch(dec_ch), .sel(dec_sel), .err(dec_err)
   );

   logic wr_ok, rd_ok;
   assign wr_ok = bus_valid && bus_write && !dec_err;
   assign rd_ok = bus_valid && !bus_write && !dec_err;

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CMD_BITS];

   logic [N_CH-1:0][1:0]          cfg_a;
   logic [N_CH-1:0][CMD_BITS-1:0] stream_a;
   logic [N_CH-1:0][ST_W-1:0]     state_all;
   logic [N_CH-1:0]               eol_a;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_ok && (dec_ch == CH_W'(c));
      dma_chan_slot #(.CMD_W(CMD_BITS)) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_cfg   (hit && dec_sel == SEL_CFG),
         .wr_cmd   (hit && dec_sel == SEL_CMD),
         .wr_stream(hit && dec_sel == SEL_STREAM),
         .wdata    (bus_wdata[CMD_BITS-1:0]),
         .client   (client_present[c]),
         .eol_in   (eol_set[c]),
         .cfg_q    (cfg_a[c]),
         .stream_q (stream_a[c]),
         .state_q  (state_all[c]),
         .eol_q    (eol_a[c]),
         .cont_p   (cont_pulse[c]),
         .ldd_p    (load_desc_pulse[c]),
         .ldc_p    (load_ctx_pulse[c]),
         .start_p  (start_pulse[c])
      );
   end

   logic [DATA_W-1:0] rdata_d;
   always_comb begin
      rdata_d = '0;
      if (rd_ok) begin
         case (dec_sel)
            SEL_CFG:    rdata_d[1:0] = cfg_a[dec_ch];
            SEL_STREAM: rdata_d[CMD_BITS-1:0] = stream_a[dec_ch];
            SEL_STATUS: begin
               rdata_d[ST_W-1:0]           = state_all[dec_ch];
               rdata_d[EOL_POS]            = eol_a[dec_ch];
               rdata_d[SRC_POS+1:SRC_POS]  = SRC_ID;
            end
            default:    rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= bus_valid;
         resp_err   <= bus_valid && dec_err;
         resp_rdata <= rdata_d;
      end
   end
endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk
   import dma_chan_regfile_pkg::*;
#(
   parameter int N_CH = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_valid,
   input logic                      resp_valid,
   input logic                      resp_err,
   input logic [N_CH-1:0]           client_present,
   input logic [N_CH-1:0]           cont_pulse,
   input logic [N_CH-1:0]           load_desc_pulse,
   input logic [N_CH-1:0]           load_ctx_pulse,
   input logic [N_CH-1:0]           start_pulse,
   input logic [N_CH-1:0][ST_W-1:0] state_all
);
   logic any_pulse;
   assign any_pulse = |{cont_pulse, load_desc_pulse, load_ctx_pulse, start_pulse};

   p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> resp_valid);
   p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !resp_valid);
   p_pulse_in_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      any_pulse |-> resp_valid);
   p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> !any_pulse);

   for (genvar c = 0; c < N_CH; c++) begin : g_chk
      p_state_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(state_all[c]) == 1);
      p_start_client_r7: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse[c] |-> $past(client_present[c]));
      p_start_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse[c] |-> state_all[c] == ST_RUNNING);
      p_cont_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cont_pulse[c] |-> $past(state_all[c]) == ST_RUNNING);
   end
endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(.N_CH(N_CH)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_valid      (bus_valid),
   .resp_valid     (resp_valid),
   .resp_err       (resp_err),
   .client_present (client_present),
   .cont_pulse     (cont_pulse),
   .load_desc_pulse(load_desc_pulse),
   .load_ctx_pulse (load_ctx_pulse),
   .start_pulse    (start_pulse),
   .state_all      (state_all)
);

// File: tb/dma_chan_regfile_tb_top.sv
module dma_chan_regfile_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [N-1:0] client_present = '0, eol_set = '0;
   logic        resp_valid, resp_err;
   logic [31:0] resp_rdata;
   logic [N-1:0] cont_pulse, load_desc_pulse, load_ctx_pulse, start_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .client_present(client_present), .eol_set(eol_set),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .cont_pulse(cont_pulse), .load_desc_pulse(load_desc_pulse),
      .load_ctx_pulse(load_ctx_pulse), .start_pulse(start_pulse)
   );

   typedef struct {
      logic [31:0]    rdata;
      logic           err;
      logic [4*N-1:0] pulses;
      string          tag;
   } exp_t;

   exp_t q[$];
   int checks = 0, errors = 0;
   bit done = 0;

   function automatic logic [4*N-1:0] pk(logic [N-1:0] st, logic [N-1:0] lc,
                                         logic [N-1:0] ld, logic [N-1:0] ct);
      return {st, lc, ld, ct};
   endfunction

   function automatic logic [15:0] ad(int ch, int off);
      return 16'((ch << 13) + off);
   endfunction

   task automatic acc(bit wr, logic [15:0] a, logic [3:0] be, logic [31:0] wd,
                      logic [31:0] er, bit ee, logic [4*N-1:0] ep, string tag);
      exp_t e;
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
      e.rdata = er; e.err = ee; e.pulses = ep; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic wr(int ch, int off, logic [31:0] d, logic [4*N-1:0] ep, string tag);
      acc(1, ad(ch, off), 4'hF, d, 32'h0, 0, ep, tag);
   endtask

   task automatic rd(int ch, int off, logic [31:0] er, string tag);
      acc(0, ad(ch, off), 4'hF, 32'h0, er, 0, '0, tag);
   endtask

   // monitor: compares each response against the queued expectation
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         exp_t e;
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected response: actual valid=1 expected none");
         end else begin
            e = q.pop_front();
            if (resp_rdata !== e.rdata || resp_err !== e.err ||
                {start_pulse, load_ctx_pulse, load_desc_pulse, cont_pulse} !== e.pulses) begin
               errors++;
               $display("FAIL %s: actual rdata=%h err=%b pulses=%h expected rdata=%h err=%b pulses=%h",
                        e.tag, resp_rdata, resp_err,
                        {start_pulse, load_ctx_pulse, load_desc_pulse, cont_pulse},
                        e.rdata, e.err, e.pulses);
            end
         end
      end else if (rst_n) begin
         checks++;
         if ({start_pulse, load_ctx_pulse, load_desc_pulse, cont_pulse} !== '0) begin
            errors++;
            $display("FAIL R1 pulse outside a response: actual %h expected 0",
                     {start_pulse, load_ctx_pulse, load_desc_pulse, cont_pulse});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0 || resp_rdata !== '0) begin
         errors++;
         $display("FAIL R2 reset outputs: actual valid=%b rdata=%h expected 0/0", resp_valid, resp_rdata);
      end
      rst_n = 1'b1;

      rd(0, 'hC, 32'h101, "R2 reset status ch0");
      rd(3, 'hC, 32'h101, "R2 reset status ch3");
      wr(0, 'h0, 32'h1, '0, "R3 enable write");
      rd(0, 'hC, 32'h101, "R3 enable leaves state");
      rd(0, 'h0, 32'h1, "R3 cfg readback");
      client_present = 4'b0001;
      wr(0, 'h4, 32'h0, '0, "R8 continue while reset state");
      wr(0, 'h8, 32'h140, pk(0, 0, 4'b0001, 0), "R4 load descriptor only");
      rd(0, 'hC, 32'h101, "R5 no start without burst");
      wr(0, 'h8, 32'h20, '0, "R5 burst alone");
      wr(0, 'h8, 32'h060, pk(4'b0001, 0, 4'b0001, 0), "R5 bit6 plus burst starts");
      rd(0, 'hC, 32'h104, "R7 running after start");
      rd(0, 'h8, 32'h060, "R4 stream readback");
      wr(0, 'h4, 32'h0, pk(0, 0, 0, 4'b0001), "R8 continue while running");
      rd(3, 'hC, 32'h101, "R11 ch3 untouched");
      @(negedge clk); eol_set = 4'b0001;
      @(negedge clk); eol_set = 4'b0000;
      rd(0, 'hC, 32'h124, "R9 eol set");
      wr(0, 'h0, 32'h3, '0, "R3 stop write");
      rd(0, 'hC, 32'h122, "R3 stopped keeps eol");
      wr(0, 'h4, 32'h0, '0, "R8 no continue when stopped");
      wr(0, 'h8, 32'h200, pk(4'b0001, 4'b0001, 0, 0), "R6 load context starts");
      rd(0, 'hC, 32'h104, "R7 start clears eol");
      wr(0, 'h4, 32'h0, '0, "R8 no continue with stop bit");
      wr(0, 'h0, 32'h2, '0, "R3 disable plus stop");
      rd(0, 'hC, 32'h101, "R3 reset wins");
      wr(1, 'h8, 32'h200, pk(0, 4'b0010, 0, 0), "R7 context load without client");
      rd(1, 'hC, 32'h101, "R7 no start without client");
      wr(2, 'h8, 32'h7FF, pk(0, 4'b0100, 4'b0100, 0), "R4 wide command low bits");
      rd(2, 'h8, 32'h3FF, "R4 only low 10 bits stored");
      wr(2, 'h8, 32'h400, '0, "R4 bit10 ignored");
      rd(2, 'h8, 32'h000, "R4 bit10 not stored");
      acc(1, ad(0, 'h0), 4'h3, 32'h1, 32'h0, 1, '0, "R10 narrow write");
      rd(0, 'h0, 32'h2, "R10 narrow write no effect");
      acc(0, 16'h8000, 4'hF, 32'h0, 32'h0, 1, '0, "R10 channel out of range");
      acc(0, ad(1, 'h10), 4'hF, 32'h0, 32'h0, 1, '0, "R10 unmapped offset");
      acc(1, ad(3, 'h8), 4'h1, 32'h200, 32'h0, 1, '0, "R10 narrow stream no pulse");
      rd(3, 'h8, 32'h0, "R10 R11 ch3 stream untouched");
      repeat (4) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R1 missing responses: actual %0d pending expected 0", q.size());
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule